// File: doc/BRIEF.md
# I2C Interrupt Status Controller

This block keeps the event flags of a register-mapped I2C master. It drives one interrupt line and two DMA request lines from them. The transfer logic raises a flag with a one-cycle set pulse and drops it with a one-cycle clear pulse. Software works through a small write port that reaches three registers: the enable mask, the status register and the DMA configuration. A self-test write can also reach the status register. Software reads the status word, with the live bus-busy level merged into bit 12, and the current enable mask and DMA configuration.

A parameter `REVISION` chooses between two acknowledge schemes. Below 0x34 (the legacy scheme), reading the vector port returns one plus the index of the lowest flag that is both pending and enabled, and clears that flag. From 0x34 upwards the vector port is inert. Software instead clears flags by writing ones to the status register, and a self-test write can force the low six flags. All three outputs are registered, and each follows the state of the previous cycle.

Top module: `i2c_isc`

## Requirements
- R1: `irq_o` is high in the cycle after one in which the AND of status bits 5..0 and the enable mask is nonzero, and low otherwise.
- R2: A set pulse on `evt_set_i[k]` sets status bit k. Only bits 0..5, 10, 11 and 15 are held; the other bits read as zero. `stat_o[12]` shows `bus_busy_i` directly.
- R3: `rx_dreq_o` equals the previous cycle's status bit 3 ANDed with the receive-DMA enable (DMA bit 15). `tx_dreq_o` equals the previous cycle's status bit 4 ANDed with the transmit-DMA enable (DMA bit 7). Each is low while its enable is clear.
- R4: A write with `wr_sel_i`=2 loads the DMA configuration with bits 15 and 7 of the data only. Data bit 15 set clears enable bit 3, and data bit 7 set clears enable bit 4.
- R5: Legacy scheme. While `vec_rd_i` is high, `vec_o` shows one plus the lowest index k for which status bit k and enable bit k are both set, or 0 if there is none. At the next edge status bit k is cleared.
- R6: Newer scheme. `vec_o` is always 0, and `vec_rd_i` changes no state.
- R7: A write with `wr_sel_i`=1 under the newer scheme clears the status bits where the data has a one, limited to mask 0x27 (bits 3 and 4 are never cleared this way). Under the legacy scheme such a write has no effect.
- R8: A write with `wr_sel_i`=0 loads the enable mask with data bits 4..0 under the legacy scheme, or with bits 5..0 under the newer scheme.
- R9: A write with `wr_sel_i`=3 and data bit 11 set forces status bits 0..5 to one under the newer scheme. Under the legacy scheme it does nothing.
- R10: A set pulse wins over a same-cycle clear of the same bit, whether the clear comes from a pulse, a status write or a vector read.
- R11: A clear pulse on `evt_clr_i[k]` clears status bit k.
- R12: During reset the status, the enable mask, the DMA configuration and all three outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_set_i | input | 16 | Per-bit status set pulses |
| evt_clr_i | input | 16 | Per-bit status clear pulses |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | 0 enable, 1 status, 2 DMA config, 3 self-test |
| wr_data_i | input | 16 | Write data |
| vec_rd_i | input | 1 | Vector read strobe |
| vec_o | output | 3 | Vector read data |
| bus_busy_i | input | 1 | Bus-busy level |
| stat_o | output | 16 | Status read data with busy on bit 12 |
| en_o | output | 6 | Enable mask read data |
| dma_o | output | 16 | DMA configuration read data |
| irq_o | output | 1 | Interrupt request |
| rx_dreq_o | output | 1 | Receive DMA request |
| tx_dreq_o | output | 1 | Transmit DMA request |

## Verification
The bench drives a legacy instance and a newer-scheme instance in parallel against a behavioural model. It targets the following cases:
- Back-to-back vector reads that drain every pending flag in order. A priority encoder that searched from the top, or that forgot to clear, would return the same or the wrong code.
- Clears that collide with set pulses in the same cycle. A design that let the clear win would lose events.
- Write-one-to-clear with all ones. A design that wiped the ready bits would break the DMA requests.
- DMA writes with enables already set, which must strip enable bits 3 and 4.
- Writes to the status register, the self-test register and the top enable bit on the legacy instance, which must leave it unchanged.

// File: rtl/i2c_isc_pkg.sv
package i2c_isc_pkg;

    localparam int STAT_W  = 16;
    localparam int EN_W    = 6;
    localparam int CODE_W  = $clog2(EN_W + 1);

    localparam logic [7:0]        NEW_REV      = 8'h34;
    localparam logic [STAT_W-1:0] STAT_IMPL    = 16'h8C3F;
    localparam logic [STAT_W-1:0] STAT_W1C     = 16'h0027;
    localparam logic [STAT_W-1:0] STAT_FORCE   = 16'h003F;

    localparam int B_RRDY  = 3;
    localparam int B_XRDY  = 4;
    localparam int B_BUSY  = 12;
    localparam int B_RXDMA = 15;
    localparam int B_TXDMA = 7;
    localparam int B_FORCE = 11;

    typedef enum logic [1:0] {
        SEL_ENABLE   = 2'd0,
        SEL_STATUS   = 2'd1,
        SEL_DMA      = 2'd2,
        SEL_SELFTEST = 2'd3
    } isc_sel_e;

    typedef struct packed {
        logic [STAT_W-1:0] stat;
        logic [EN_W-1:0]   en;
        logic              rx_dma;
        logic              tx_dma;
    } isc_state_t;

    typedef struct packed {
        logic irq;
        logic rx_req;
        logic tx_req;
    } isc_out_t;

endpackage

// File: rtl/isc_prio_pick.sv
module isc_prio_pick #(
    parameter int N      = 6,
    parameter int CODE_W = $clog2(N + 1)
) (
    input  logic [N-1:0]      req_i,
    output logic              found_o,
    output logic [CODE_W-1:0] code_o
);

    // lowest index wins: scan from the top so the last hit is the lowest
    always_comb begin
        found_o = 1'b0;
        code_o  = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                found_o = 1'b1;
                code_o  = CODE_W'(i + 1);
            end
        end
    end

endmodule

// File: rtl/isc_out_stage.sv
module isc_out_stage
    import i2c_isc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] stat_i,
    input  logic [EN_W-1:0]   en_i,
    input  logic              rx_dma_i,
    input  logic              tx_dma_i,
    output logic              irq_o,
    output logic              rx_dreq_o,
    output logic              tx_dreq_o
);

    isc_out_t out_d, out_q;

    always_comb begin
        out_d        = out_q;
        out_d.irq    = |(stat_i[EN_W-1:0] & en_i);
        out_d.rx_req = rx_dma_i && stat_i[B_RRDY];
        out_d.tx_req = tx_dma_i && stat_i[B_XRDY];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign irq_o     = out_q.irq;
    assign rx_dreq_o = out_q.rx_req;
    assign tx_dreq_o = out_q.tx_req;

    p_irq_lag_r1: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_o == $past(|(stat_i[EN_W-1:0] & en_i))));

endmodule

// File: rtl/i2c_isc.sv
module i2c_isc
    import i2c_isc_pkg::*;
#(
    parameter logic [7:0] REVISION = 8'h20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] evt_set_i,
    input  logic [STAT_W-1:0] evt_clr_i,
    input  logic              wr_en_i,
    input  logic [1:0]        wr_sel_i,
    input  logic [STAT_W-1:0] wr_data_i,
    input  logic              vec_rd_i,
    output logic [CODE_W-1:0] vec_o,
    input  logic              bus_busy_i,
    output logic [STAT_W-1:0] stat_o,
    output logic [EN_W-1:0]   en_o,
    output logic [STAT_W-1:0] dma_o,
    output logic              irq_o,
    output logic              rx_dreq_o,
    output logic              tx_dreq_o
);

    localparam bit NEW_SCHEME = (REVISION >= NEW_REV);
    localparam logic [EN_W-1:0] EN_WMASK =
        NEW_SCHEME ? {EN_W{1'b1}} : {1'b0, {(EN_W-1){1'b1}}};

    isc_state_t        st_d, st_q;
    isc_sel_e          sel;
    logic [CODE_W-1:0] vec_code;
    logic [STAT_W-1:0] vec_clr;
    logic [STAT_W-1:0] clr_all, set_all;

    assign sel = isc_sel_e'(wr_sel_i);

    // vector decode only exists under the legacy scheme
    generate
        if (!NEW_SCHEME) begin : g_legacy_vec
            logic vec_found;
            isc_prio_pick #(.N(EN_W), .CODE_W(CODE_W)) u_pick (
                .req_i   (st_q.stat[EN_W-1:0] & st_q.en),
                .found_o (vec_found),
                .code_o  (vec_code)
            );
            assign vec_clr = vec_found ? (STAT_W'(1) << (vec_code - CODE_W'(1))) : '0;

            p_vec_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (vec_rd_i && vec_code != '0 && evt_set_i == '0) |=>
                (((st_q.stat >> ($past(vec_code) - CODE_W'(1))) & STAT_W'(1)) == '0));
        end else begin : g_new_vec
            assign vec_code = '0;
            assign vec_clr  = '0;

            p_w1c_keeps_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en_i && wr_sel_i == 2'd1 && evt_clr_i[B_XRDY:B_RRDY] == 2'b00
                 && evt_set_i[B_XRDY:B_RRDY] == 2'b00) |=>
                (st_q.stat[B_XRDY:B_RRDY] == $past(st_q.stat[B_XRDY:B_RRDY])));
        end
    endgenerate

    always_comb begin
        st_d    = st_q;
        clr_all = evt_clr_i;
        set_all = evt_set_i;

        if (vec_rd_i) begin
            clr_all = clr_all | vec_clr;
        end

        if (wr_en_i) begin
            unique case (sel)
                SEL_ENABLE: begin
                    st_d.en = wr_data_i[EN_W-1:0] & EN_WMASK;
                end
                SEL_STATUS: begin
                    if (NEW_SCHEME) begin
                        clr_all = clr_all | (wr_data_i & STAT_W1C);
                    end
                end
                SEL_DMA: begin
                    st_d.rx_dma = wr_data_i[B_RXDMA];
                    st_d.tx_dma = wr_data_i[B_TXDMA];
                    if (wr_data_i[B_RXDMA]) st_d.en[B_RRDY] = 1'b0;
                    if (wr_data_i[B_TXDMA]) st_d.en[B_XRDY] = 1'b0;
                end
                SEL_SELFTEST: begin
                    if (NEW_SCHEME && wr_data_i[B_FORCE]) begin
                        set_all = set_all | STAT_FORCE;
                    end
                end
                default: ;
            endcase
        end

        // set pulses are applied last so they win over any clear
        st_d.stat = ((st_q.stat & ~clr_all) | set_all) & STAT_IMPL;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    isc_out_stage u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .stat_i    (st_q.stat),
        .en_i      (st_q.en),
        .rx_dma_i  (st_q.rx_dma),
        .tx_dma_i  (st_q.tx_dma),
        .irq_o     (irq_o),
        .rx_dreq_o (rx_dreq_o),
        .tx_dreq_o (tx_dreq_o)
    );

    always_comb begin
        stat_o         = st_q.stat;
        stat_o[B_BUSY] = bus_busy_i;
    end
    assign en_o  = st_q.en;
    assign dma_o = {st_q.rx_dma, 7'b0, st_q.tx_dma, 7'b0};
    assign vec_o = vec_code;

    p_dma_strip_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_sel_i == 2'd2 && wr_data_i[B_RXDMA]) |=> !st_q.en[B_RRDY]);

    p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_set_i) |=>
        ((st_q.stat & $past(evt_set_i & STAT_IMPL)) == $past(evt_set_i & STAT_IMPL)));

    p_unimpl_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((st_q.stat & ~STAT_IMPL) == '0));

    p_dreq_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.rx_dma |=> !rx_dreq_o);

endmodule

// File: tb/i2c_isc_tb_top.sv
`timescale 1ns/1ps
module i2c_isc_tb_top;

    logic        clk = 1'b0;
    always #2 clk = ~clk;

    logic        rst_n;
    logic [15:0] evt_set, evt_clr, wr_data;
    logic        wr_en, vec_rd, busy;
    logic [1:0]  wr_sel;

    logic [2:0]  vec_a [2];
    logic [15:0] stat_a [2];
    logic [5:0]  en_a [2];
    logic [15:0] dma_a [2];
    logic        irq_a [2], rxr_a [2], txr_a [2];

    i2c_isc #(.REVISION(8'h20)) dut_i (
        .clk(clk), .rst_n(rst_n), .evt_set_i(evt_set), .evt_clr_i(evt_clr),
        .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data), .vec_rd_i(vec_rd),
        .vec_o(vec_a[0]), .bus_busy_i(busy), .stat_o(stat_a[0]), .en_o(en_a[0]),
        .dma_o(dma_a[0]), .irq_o(irq_a[0]), .rx_dreq_o(rxr_a[0]), .tx_dreq_o(txr_a[0]));

    i2c_isc #(.REVISION(8'h34)) dut_new_i (
        .clk(clk), .rst_n(rst_n), .evt_set_i(evt_set), .evt_clr_i(evt_clr),
        .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data), .vec_rd_i(vec_rd),
        .vec_o(vec_a[1]), .bus_busy_i(busy), .stat_o(stat_a[1]), .en_o(en_a[1]),
        .dma_o(dma_a[1]), .irq_o(irq_a[1]), .rx_dreq_o(rxr_a[1]), .tx_dreq_o(txr_a[1]));

    int checks = 0;
    int fails  = 0;
    bit cmp_on = 0;
    bit in_rst = 0;

    // behavioural model, index 0 legacy, index 1 newer scheme
    logic [15:0] m_stat [2];
    logic [5:0]  m_en [2];
    logic        m_rxd [2], m_txd [2], m_irq [2], m_rxq [2], m_txq [2];
    logic [15:0] t_clr, t_set;
    int          t_vc;

    function automatic int m_vec(int r);
        if (r == 1) return 0;
        for (int i = 0; i < 6; i++)
            if (m_stat[r][i] && m_en[r][i]) return i + 1;
        return 0;
    endfunction

    always @(posedge clk) begin
        for (int r = 0; r < 2; r++) begin
            if (!rst_n) begin
                m_stat[r] = '0; m_en[r] = '0; m_rxd[r] = 0; m_txd[r] = 0;
                m_irq[r] = 0; m_rxq[r] = 0; m_txq[r] = 0;
            end else begin
                m_irq[r] = |(m_stat[r][5:0] & m_en[r]);
                m_rxq[r] = m_rxd[r] && m_stat[r][3];
                m_txq[r] = m_txd[r] && m_stat[r][4];
                t_clr = evt_clr;
                t_set = evt_set;
                t_vc  = m_vec(r);
                if (vec_rd && t_vc != 0) t_clr[t_vc-1] = 1'b1;
                if (wr_en) begin
                    case (wr_sel)
                        2'd0: m_en[r] = wr_data[5:0] & (r == 1 ? 6'h3F : 6'h1F);
                        2'd1: if (r == 1) t_clr = t_clr | (wr_data & 16'h0027);
                        2'd2: begin
                            m_rxd[r] = wr_data[15];
                            m_txd[r] = wr_data[7];
                            if (wr_data[15]) m_en[r][3] = 1'b0;
                            if (wr_data[7])  m_en[r][4] = 1'b0;
                        end
                        default: if (r == 1 && wr_data[11]) t_set = t_set | 16'h003F;
                    endcase
                end
                m_stat[r] = ((m_stat[r] & ~t_clr) | t_set) & 16'h8C3F;
            end
        end
    end

    task automatic chk(string tag, int r, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s dut%0d t=%0t actual=%h expected=%h", tag, r, $time, act, exp);
        end
    endtask

    always @(negedge clk) begin
        #1;
        if (cmp_on) begin
            for (int r = 0; r < 2; r++) begin
                if (in_rst) begin
                    chk("R12 reset status", r, stat_a[r] & 16'hEFFF, 16'h0);
                    chk("R12 reset outputs", r, {13'b0, irq_a[r], rxr_a[r], txr_a[r]}, 16'h0);
                end
                chk("R2 R7 R9 R10 R11 status", r, stat_a[r],
                    (m_stat[r] & 16'hEFFF) | (16'(busy) << 12));
                chk("R4 R8 enable", r, 16'(en_a[r]), 16'(m_en[r]));
                chk("R4 dma config", r, dma_a[r], {m_rxd[r], 7'b0, m_txd[r], 7'b0});
                chk("R5 R6 vector", r, 16'(vec_a[r]), 16'(vec_rd ? m_vec(r) : m_vec(r)));
                chk("R1 irq", r, 16'(irq_a[r]), 16'(m_irq[r]));
                chk("R3 dma requests", r, {14'b0, rxr_a[r], txr_a[r]}, {14'b0, m_rxq[r], m_txq[r]});
            end
        end
    end

    task automatic step(logic [15:0] s, logic [15:0] c, logic we, logic [1:0] ws,
                        logic [15:0] wd, logic vr, logic bb);
        evt_set = s; evt_clr = c; wr_en = we; wr_sel = ws; wr_data = wd;
        vec_rd = vr; busy = bb;
        @(negedge clk);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step('0, '0, 0, 2'd0, '0, 0, 0);
    endtask

    initial begin
        rst_n = 0; in_rst = 1;
        evt_set = '0; evt_clr = '0; wr_en = 0; wr_sel = '0; wr_data = '0; vec_rd = 0; busy = 0;
        @(posedge clk);
        cmp_on = 1;
        @(negedge clk);
        step('0, '0, 0, 2'd0, '0, 0, 1);
        step(16'hFFFF, '0, 1, 2'd0, 16'hFFFF, 0, 0);
        rst_n = 1; in_rst = 0;
        // R8 enable width, R2 implemented bits
        step('0, '0, 1, 2'd0, 16'hFFFF, 0, 0);
        step(16'hFFFF, '0, 0, 2'd0, '0, 0, 1);
        idle(2);
        // R5 drain by vector reads, R6 new scheme ignores
        for (int i = 0; i < 7; i++) step('0, '0, 0, 2'd0, '0, 1, 0);
        // R5 no pending returns 0, then one pending with set/clear collision R10
        step(16'h0004, 16'h0004, 0, 2'd0, '0, 1, 0);
        step('0, '0, 0, 2'd0, '0, 1, 0);
        // R9 self-test force, legacy ignores
        step('0, '0, 1, 2'd3, 16'h0800, 0, 0);
        idle(1);
        // R7 write all ones to status
        step('0, '0, 1, 2'd1, 16'hFFFF, 0, 0);
        idle(1);
        // R10 set wins over write-one-to-clear, R11 pulse clear
        step(16'h0001, '0, 1, 2'd1, 16'h0001, 0, 0);
        step('0, 16'h0008, 0, 2'd0, '0, 0, 0);
        // R4 dma strips enables, R3 requests follow ready
        step('0, '0, 1, 2'd0, 16'h003F, 0, 0);
        step(16'h0018, '0, 1, 2'd2, 16'hFFFF, 0, 0);
        idle(2);
        step('0, 16'h0010, 0, 2'd0, '0, 0, 0);
        idle(2);
        step('0, '0, 1, 2'd2, 16'h0000, 0, 0);
        idle(2);
        for (int i = 0; i < 5000; i++) begin
            step(16'($urandom & $urandom & $urandom), 16'($urandom & $urandom & $urandom),
                 ($urandom % 4) == 0, 2'($urandom), 16'($urandom),
                 ($urandom % 3) == 0, 1'($urandom));
        end
        idle(2);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(4 * 200000);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule